// File: doc/BRIEF.md
# TDM Input Sampling Delay Front End

This block is the input stage for one group of serial TDM streams. It runs on a clock at four times the serial bit rate, so one clock cycle, or tick, is a quarter of a bit. A 5-bit delay code chooses the tick inside the bit grid at which each incoming bit is taken. One optional inversion applies to every line. The sampled bits are packed most significant bit first into one byte per channel, and each byte is lined up to the frame pulse. Every stream in the group shares one delay code and one invert setting.

Each finished byte comes out on a per-stream byte bus, together with its channel number and a one-cycle strobe. A parameter selects a coarser variant for the case where an external reference clock times the group. In that variant the sampling step is half a bit, so the least significant code bit has no effect. A new setting is accepted only at a frame boundary. A single frame is therefore never sampled under two settings.

Top module: `tdm_sample_delay`

## Requirements
- R1: While rst_n is low at a clock edge, byte_vld, ch_data and ch_idx become zero. From reset release until the first frame pulse, the block uses code 4 with no inversion, ignores delay_code and invert, and counts the first cycle after reset as frame tick 0.
- R2: A cycle with frame_pulse high is tick 0 of a frame that lasts CHANNELS*32 ticks (4 ticks per bit, 8 bits per channel). A pulse that arrives before the frame has ended restarts the count from 0.
- R3: Let E be the effective code. Bit k (k=0 is the first bit) of channel c is sampled at frame tick 32c+4k+E-1, taken modulo the frame length. Code 4 samples at the 3/4 point of the bit cell, and code 15 puts the first bit of the frame 3.5 bits after the boundary. ch_idx reports c.
- R4: Bits are packed most significant bit first: bit k of a channel lands in bit 7-k of that stream's byte.
- R5: byte_vld is high for one cycle only. That cycle is the one after the tick on which the eighth bit of a channel is sampled. There is exactly one strobe for every eight samples.
- R6: The stream on ser_in[s] is delivered on ch_data[8s+7:8s]. All streams are sampled on the same ticks and under the same setting.
- R7: When the invert setting in force is 1, every sampled bit is complemented before it is packed.
- R8: delay_code and invert are read only in a cycle where frame_pulse is high, and they apply from that tick onward. Changes at any other time have no effect.
- R9: With parameter STEP_TICKS=2, the effective code is delay_code with its least significant bit cleared, so codes 2n and 2n+1 behave the same.
- R10: Code 0 samples the first bit of a frame one tick before the frame pulse, on the last tick of the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four ticks per serial bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | Marks tick 0 of a frame; the delay and invert settings are loaded here |
| ser_in | input | NSTREAMS | Serial data lines of the group |
| delay_code | input | 5 | Sampling delay in quarter-bit steps |
| invert | input | 1 | Complement all sampled bits |
| ch_data | output | NSTREAMS*8 | Last completed byte of each stream |
| ch_idx | output | log2(CHANNELS) | Channel number of the bytes on ch_data |
| byte_vld | output | NSTREAMS | One-cycle strobe per stream when a new byte is present |

## Verification
The input lines carry a pattern that changes on every tick. An off-by-one-tick sampling point, or a reversed bit order, therefore corrupts the recovered bytes and does not go unnoticed. The bench changes the code and the invert bit in the middle of a frame. A design that applied them at once would shift its strobe position, or corrupt data, before the boundary. Code 0 and code 31 exercise the wrap across the frame end, where a design with wrong modular arithmetic would strobe the wrong channel or lose the first bit. An early frame pulse and a second instance with half-bit steps catch designs that do not restart the count, or that still honour the least significant code bit.

// File: rtl/psd_pkg.sv
// Shared constants and types for the TDM input sampling delay front end.
// Assumes four oversample ticks per bit and eight bits per channel.
package psd_pkg;
    localparam int OSR        = 4;
    localparam int BYTE_BITS  = 8;
    localparam int CODE_W     = 5;
    localparam int SLOT_TICKS = OSR * BYTE_BITS;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              inv;
    } samp_cfg_t;
endpackage

// File: rtl/psd_frame_timer.sv
// Frame tick counter and sampling-instant decoder for one stream group.
// Loads the sampling setting only on the frame-pulse tick. From the effective
// code it derives when to sample, when a byte is complete, and which channel.
// Assumes CHANNELS is a power of two, so the frame wraps by truncation.
module psd_frame_timer
    import psd_pkg::*;
#(
    parameter int                CHANNELS     = 32,
    parameter int                STEP_TICKS   = 1,
    parameter logic [CODE_W-1:0] DEFAULT_CODE = 5'd4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_pulse,
    input  samp_cfg_t                   cfg_in,
    output logic                        samp_en,
    output logic                        byte_done,
    output logic [$clog2(CHANNELS)-1:0] chan,
    output logic                        inv_act
);
    localparam int FRAME_TICKS = CHANNELS * SLOT_TICKS;
    localparam int TICK_W      = $clog2(FRAME_TICKS);
    localparam int CH_W        = $clog2(CHANNELS);
    localparam int OSR_W       = $clog2(OSR);
    localparam int SLOT_W      = $clog2(SLOT_TICKS);

    logic [TICK_W-1:0] tick_q, tick_cur, rel;
    samp_cfg_t         cfg_q, cfg_cur;
    logic [CODE_W-1:0] eff_code;

    // Current tick and setting: the frame pulse forces tick 0 and the new setting.
    always_comb begin
        tick_cur = frame_pulse ? '0 : tick_q;
        cfg_cur  = frame_pulse ? cfg_in : cfg_q;
    end

    // Pick the step size: half-bit steps drop the least significant code bit.
    generate
        if (STEP_TICKS == 2) begin : g_half_bit
            assign eff_code = {cfg_cur.code[CODE_W-1:1], 1'b0};
        end else begin : g_quarter_bit
            assign eff_code = cfg_cur.code;
        end
    endgenerate

    // Position relative to the shifted bit grid; its fields give bit and channel.
    always_comb begin
        rel       = tick_cur + TICK_W'(1) - TICK_W'(eff_code);
        samp_en   = (rel[OSR_W-1:0] == '0);
        byte_done = samp_en && (rel[SLOT_W-1:OSR_W] == '1);
        chan      = rel[TICK_W-1 -: CH_W];
        inv_act   = cfg_cur.inv;
    end

    // Advance the frame tick counter and hold the setting that is in force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            cfg_q  <= '{code: DEFAULT_CODE, inv: 1'b0};
        end else begin
            tick_q <= tick_cur + TICK_W'(1);
            cfg_q  <= cfg_cur;
        end
    end

    // Samples are one bit apart, except across a frame pulse.
    assert_sample_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |=> (frame_pulse || !samp_en));

    // The setting in force changes only on a frame-pulse tick.
    assert_setting_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(cfg_q));
endmodule

// File: rtl/psd_lane.sv
// One serial stream: applies the group inversion, shifts the sampled bits in
// most significant bit first, and captures a byte when the eighth bit arrives.
// Assumes the sample and byte-complete enables come from the shared frame timer.
module psd_lane
    import psd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 din,
    input  logic                 inv,
    input  logic                 samp_en,
    input  logic                 byte_done,
    output logic [BYTE_BITS-1:0] byte_q
);
    logic [BYTE_BITS-2:0] sr_q;
    logic                 bit_now;

    // Polarity correction of the incoming line.
    assign bit_now = din ^ inv;

    // Shift register for the bits already taken in the current channel.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (samp_en) sr_q <= {sr_q[BYTE_BITS-3:0], bit_now};
    end

    // Byte capture on the final bit of a channel.
    always_ff @(posedge clk) begin
        if (!rst_n)         byte_q <= '0;
        else if (byte_done) byte_q <= {sr_q, bit_now};
    end

    // A byte can complete only on a sampling tick.
    assert_done_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> samp_en);
endmodule

// File: rtl/tdm_sample_delay.sv
// Group front end: a single frame timer drives NSTREAMS lanes with the same
// sampling instants. Registers the channel number and the byte strobe.
// Assumes frame_pulse is synchronous to the oversampling clock.
module tdm_sample_delay
    import psd_pkg::*;
#(
    parameter int                NSTREAMS     = 4,
    parameter int                CHANNELS     = 32,
    parameter int                STEP_TICKS   = 1,
    parameter logic [CODE_W-1:0] DEFAULT_CODE = 5'd4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_pulse,
    input  logic [NSTREAMS-1:0]             ser_in,
    input  logic [CODE_W-1:0]               delay_code,
    input  logic                            invert,
    output logic [NSTREAMS*BYTE_BITS-1:0]   ch_data,
    output logic [$clog2(CHANNELS)-1:0]     ch_idx,
    output logic [NSTREAMS-1:0]             byte_vld
);
    localparam int CH_W = $clog2(CHANNELS);

    logic            samp_en, byte_done, inv_act, vld_q;
    logic [CH_W-1:0] chan, idx_q;

    psd_frame_timer #(
        .CHANNELS    (CHANNELS),
        .STEP_TICKS  (STEP_TICKS),
        .DEFAULT_CODE(DEFAULT_CODE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .cfg_in     ('{code: delay_code, inv: invert}),
        .samp_en    (samp_en),
        .byte_done  (byte_done),
        .chan       (chan),
        .inv_act    (inv_act)
    );

    generate
        for (genvar s = 0; s < NSTREAMS; s++) begin : g_lane
            psd_lane u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .din      (ser_in[s]),
                .inv      (inv_act),
                .samp_en  (samp_en),
                .byte_done(byte_done),
                .byte_q   (ch_data[s*BYTE_BITS +: BYTE_BITS])
            );
        end
    endgenerate

    // Strobe and channel number, registered in step with the lane bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
        end else begin
            vld_q <= byte_done;
            if (byte_done) idx_q <= chan;
        end
    end

    assign byte_vld = {NSTREAMS{vld_q}};
    assign ch_idx   = idx_q;

    // Reset clears every output.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (byte_vld == '0 && ch_data == '0 && ch_idx == '0));

    // No two strobes in a row unless a frame pulse realigned the grid.
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld[0] && !frame_pulse) |=> !byte_vld[0]);
endmodule

// File: tb/tdm_sample_delay_tb.sv
`timescale 1ns/1ps
module tdm_sample_delay_tb;
    localparam int NS    = 4;
    localparam int CH    = 32;
    localparam int FRAME = CH * 32;
    localparam int DEF   = 4;
    // Scenario table: delay code, invert, frames to run.
    localparam int NSCEN = 7;
    localparam int SCEN [NSCEN][3] = '{
        '{4, 0, 2},   // default 3/4 point (R3)
        '{15, 0, 2},  // first bit 3.5 bits late (R3), coarse 14 (R9)
        '{0, 0, 2},   // sample before the boundary (R10)
        '{1, 1, 2},   // inverted lines (R7)
        '{31, 0, 2},  // largest delay, wraps the frame end
        '{6, 1, 2},
        '{14, 0, 2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fp = 1'b0;
    logic [NS-1:0]     ser = '0;
    logic [4:0]        code = 5'd9;
    logic              inv = 1'b1;
    logic [NS*8-1:0]   d_data, c_data;
    logic [4:0]        d_idx, c_idx;
    logic [NS-1:0]     d_vld, c_vld;

    int errors = 0;
    int checks = 0;
    int t = 0;
    int ftick = -1;
    int act_code = DEF;
    int act_inv = 0;
    int epoch = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_sample_delay #(.NSTREAMS(NS), .CHANNELS(CH), .STEP_TICKS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(fp), .ser_in(ser),
        .delay_code(code), .invert(inv),
        .ch_data(d_data), .ch_idx(d_idx), .byte_vld(d_vld));

    tdm_sample_delay #(.NSTREAMS(NS), .CHANNELS(CH), .STEP_TICKS(2)) u_dut_coarse (
        .clk(clk), .rst_n(rst_n), .frame_pulse(fp), .ser_in(ser),
        .delay_code(code), .invert(inv),
        .ch_data(c_data), .ch_idx(c_idx), .byte_vld(c_vld));

    // Line pattern that changes on every tick and differs per stream.
    function automatic bit stim(int s, int tt);
        int unsigned h;
        h = int'(tt) * 32'd2654435761 + int'(s) * 32'd40503;
        h = h ^ (h >> 15);
        return h[7];
    endfunction

    task automatic fail(string msg);
        errors++;
        $display("FAIL %s", msg);
    endtask

    // Check the outputs that follow the sample taken at tick t-1.
    task automatic compare(int step, logic [NS*8-1:0] data, logic [4:0] idx,
                           logic [NS-1:0] vld, string who);
        int eff, tp, rel;
        bit ev;
        logic [7:0] expb;
        eff = (step == 2) ? (act_code & ~1) : act_code;
        tp  = t - 1;
        rel = ((ftick + 1 - eff) % FRAME + FRAME) % FRAME;
        ev  = (rel % 32) == 28;
        checks++;
        if (vld !== {NS{ev}})
            fail($sformatf("R5 %s strobe at tick %0d: got %b exp %b", who, tp, vld, {NS{ev}}));
        if (ev && vld[0] === 1'b1) begin
            checks++;
            if (idx !== 5'(rel / 32))
                fail($sformatf("R3 %s channel: got %0d exp %0d", who, idx, rel / 32));
            if (tp - 28 >= epoch) begin
                for (int s = 0; s < NS; s++) begin
                    for (int j = 0; j < 8; j++)
                        expb[7-j] = stim(s, tp - 28 + 4*j) ^ act_inv[0];
                    checks++;
                    if (data[8*s +: 8] !== expb)
                        fail($sformatf("R3/R4/R6/R7/R8/R10 %s stream %0d ch %0d: got %h exp %h",
                                       who, s, rel / 32, data[8*s +: 8], expb));
                end
            end
        end
    endtask

    // Check the previous tick, then drive the next one.
    task automatic tick(bit do_fp);
        @(negedge clk);
        if (t > 0) begin
            compare(1, d_data, d_idx, d_vld, "main");
            compare(2, c_data, c_idx, c_vld, "coarse R9");
        end
        rst_n = 1'b1;
        fp = do_fp;
        for (int s = 0; s < NS; s++) ser[s] = stim(s, t);
        if (do_fp) begin
            if (int'(code) != act_code || int'(inv) != act_inv || ftick != FRAME - 1) epoch = t;
            act_code = int'(code);
            act_inv  = int'(inv);
            ftick = 0;
        end else begin
            ftick = (ftick + 1) % FRAME;
        end
        t++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick(ftick == FRAME - 1);
    endtask

    initial begin
        // R1: reset clears outputs, whatever the inputs do.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ser = ~ser;
            checks++;
            if (d_vld !== '0 || d_data !== '0 || d_idx !== '0)
                fail($sformatf("R1 reset outputs: got vld=%b data=%h idx=%0d exp 0",
                               d_vld, d_data, d_idx));
        end
        // R1: no frame pulse yet, so code 9 / invert 1 on the inputs are ignored.
        run(100);
        // Walk the table: each setting changes mid-frame and applies at the next boundary (R8).
        for (int k = 0; k < NSCEN; k++) begin
            while (ftick != 500) tick(ftick == FRAME - 1);
            code = 5'(SCEN[k][0]);
            inv  = SCEN[k][1][0];
            run(SCEN[k][2] * FRAME);
        end
        // R2: an early frame pulse restarts the frame count.
        while (ftick != 299) tick(ftick == FRAME - 1);
        tick(1'b1);
        run(2 * FRAME);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule